// File: doc/BRIEF.md
# Payload CRC-16 Checksum Unit

This unit computes the 16-bit checksum that closes every long packet of a camera serial link. A packet supervisor pulses a start input when a new long packet begins. It then presents each payload byte together with a valid strobe, in the same cycle that the byte is forwarded to the lane. After the last payload byte has been accepted, the supervisor reads the registered checksum output and sends it as the two-byte packet footer.

The checksum is the bit-reversed form of the CRC-16 with generator x^16 + x^12 + x^5 + 1. The register starts at all ones, takes the bits of each byte least significant bit first, and has no inversion applied at the end. A whole byte is folded in per clock through eight unrolled single-bit stages. The register value itself is the footer.

Top module: `payload_crc16`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `crcOut` equals 0xFFFF.
- R2: When `pktStart` is high and `byteValid` is low at a rising edge, `crcOut` equals 0xFFFF after that edge.
- R3: When `byteValid` is high and `pktStart` is low at a rising edge, the value of `crcOut` after that edge is the current value advanced by the 8 bits of `byteIn`. Bit 0 goes first. For each bit, the feedback is crc[0] XOR the data bit; the register shifts right by one; if the feedback is 1, the result is XORed with 0x8408.
- R4: When both `pktStart` and `byteValid` are low at a rising edge, `crcOut` keeps its value, whatever `byteIn` carries.
- R5: When `pktStart` and `byteValid` are both high at a rising edge, the byte is folded into the seed. `crcOut` becomes 0xFFFF advanced by `byteIn` according to R3, so the first payload byte may share the cycle with the start pulse.
- R6: No final XOR is applied. After a start pulse, the bytes FF 00 00 00 1E F0 1E C7 4F 82 78 C5 82 E0 8C 70 D2 3C 78 E9 FF 00 00 01 leave `crcOut` at 0xE569.
- R7: Bytes can be accepted on every consecutive clock with no idle cycles in between. Each byte is reflected in `crcOut` one edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | Load the seed value at the start of a long packet |
| byteValid | input | 1 | `byteIn` holds a payload byte to fold into the checksum |
| byteIn | input | 8 | Payload byte |
| crcOut | output | 16 | Registered checksum; this is the footer value after the last byte |

## Verification
The assertions check the following on every cycle:
- The register holds when neither strobe is active.
- A start pulse without a byte lands on the seed.
- Every accepted byte moves the register by exactly one byte step, whether it comes alone or together with a start pulse. This is checked through a table-style formulation of the step rather than the bit-serial one.

Only the bench's scenarios can show the rest:
- The complete packet result, including the absence of a final inversion, through the known 24-byte answer.
- The bit order across long runs of back-to-back bytes.
- The reset value after a reset in the middle of a packet.

// File: rtl/payload_crc_pkg.sv
package payload_crc_pkg;

  localparam int unsigned CRC_W_DEF  = 16;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam logic [15:0] POLY_REV_DEF = 16'h8408;
  localparam logic [15:0] SEED_DEF     = 16'hFFFF;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;  // restart from the seed
    logic step;  // fold the presented byte in
  } ctrlStrb_t;

  // Table-style contribution of one byte index pushed through a zero register.
  // Used by checks as an alternative formulation of the byte step.
  function automatic logic [15:0] crcTableEntry(input logic [7:0] idx);
    logic [15:0] acc;
    acc = {8'h00, idx};
    for (int b = 0; b < 8; b++) begin
      if (acc[0]) acc = (acc >> 1) ^ POLY_REV_DEF;
      else        acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/payload_crc_ctrl.sv
module payload_crc_ctrl
  import payload_crc_pkg::*;
(
  input  logic      pktStart,
  input  logic      byteValid,
  output ctrlStrb_t strb
);

  // Start and byte may coincide: both strobes go out and the datapath
  // folds the byte into the seed rather than into the old value.
  always_comb begin
    strb      = '0;
    strb.load = pktStart;
    strb.step = byteValid;
  end

endmodule

// File: rtl/payload_crc_dp.sv
module payload_crc_dp
  import payload_crc_pkg::*;
#(
  parameter int unsigned       CRC_W    = CRC_W_DEF,
  parameter int unsigned       BYTE_W   = BYTE_W_DEF,
  parameter logic [CRC_W-1:0]  POLY_REV = POLY_REV_DEF,
  parameter logic [CRC_W-1:0]  SEED     = SEED_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [CRC_W-1:0]  crcOut
);

  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] stage [0:BYTE_W];

  // Base of the unrolled chain: seed on a packet start, else the register
  assign stage[0] = strb.load ? SEED : crcQ;

  // One reflected shift per input bit, least significant bit first
  for (genvar g = 0; g < BYTE_W; g++) begin : gBit
    logic fb;
    assign fb           = stage[g][0] ^ byteIn[g];
    assign stage[g + 1] = (stage[g] >> 1) ^ (fb ? POLY_REV : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          crcQ <= SEED;
    else if (strb.step) crcQ <= stage[BYTE_W];
    else if (strb.load) crcQ <= SEED;
  end

  assign crcOut = crcQ;

  // R3
  byte_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=>
      ((crcQ ^ ($past(crcQ) >> BYTE_W)) ==
       crcTableEntry($past(crcQ[7:0] ^ byteIn))));

  // R5
  merged_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.load) |=>
      ((crcQ ^ (SEED >> BYTE_W)) ==
       crcTableEntry(SEED[7:0] ^ $past(byteIn))));

endmodule

// File: rtl/payload_crc16.sv
module payload_crc16
  import payload_crc_pkg::*;
#(
  parameter int unsigned       CRC_W    = CRC_W_DEF,
  parameter int unsigned       BYTE_W   = BYTE_W_DEF,
  parameter logic [CRC_W-1:0]  POLY_REV = POLY_REV_DEF,
  parameter logic [CRC_W-1:0]  SEED     = SEED_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktStart,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [CRC_W-1:0]  crcOut
);

  ctrlStrb_t strb;

  payload_crc_ctrl i_ctrl (
    .pktStart (pktStart),
    .byteValid(byteValid),
    .strb     (strb)
  );

  payload_crc_dp #(
    .CRC_W   (CRC_W),
    .BYTE_W  (BYTE_W),
    .POLY_REV(POLY_REV),
    .SEED    (SEED)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .byteIn(byteIn),
    .crcOut(crcOut)
  );

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pktStart && !byteValid) |=> $stable(crcOut));

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktStart && !byteValid) |=> (crcOut == SEED));

endmodule

// File: tb/test_payload_crc16.sv
module test_payload_crc16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktStart = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic [15:0] crcOut;

  int unsigned testsRun = 0;
  int unsigned testsFailed = 0;
  int unsigned cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  payload_crc16 i_payload_crc16 (
    .clk      (clk),
    .rstN     (rstN),
    .pktStart (pktStart),
    .byteValid(byteValid),
    .byteIn   (byteIn),
    .crcOut   (crcOut)
  );

  // Entry layout: [9] start, [8] valid, [7:0] byte
  localparam int NVEC = 30;
  localparam logic [9:0] VEC [NVEC] = '{
    10'h200,
    10'h1FF, 10'h100, 10'h100, 10'h100, 10'h11E, 10'h1F0, 10'h11E, 10'h1C7,
    10'h14F, 10'h182, 10'h178, 10'h1C5, 10'h182, 10'h1E0, 10'h18C, 10'h170,
    10'h1D2, 10'h13C, 10'h178, 10'h1E9, 10'h1FF, 10'h100, 10'h100, 10'h101,
    10'h033, 10'h3A5, 10'h101, 10'h180, 10'h200
  };

  function automatic logic [15:0] refStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb;
      fb = r[0] ^ d[b];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    testsRun++;
    if (crcOut !== exp) begin
      testsFailed++;
      $display("FAIL %s: crcOut=%h expected=%h", req, crcOut, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic drive(input logic s, input logic v, input logic [7:0] d);
    pktStart  = s;
    byteValid = v;
    byteIn    = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 5000);
      finishRun();
    end
  end

  initial begin
    logic [15:0] model;
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'hFFFF);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 after release", 16'hFFFF);

    // Vector walk: back-to-back bytes exercise R7
    model = 16'hFFFF;
    for (int i = 0; i < NVEC; i++) begin
      logic s;
      logic v;
      logic [7:0] d;
      s = VEC[i][9];
      v = VEC[i][8];
      d = VEC[i][7:0];
      if (s && v)  model = refStep(16'hFFFF, d);
      else if (v)  model = refStep(model, d);
      else if (s)  model = 16'hFFFF;
      drive(s, v, d);
      if (s && v)      check("R5 start with byte", model);
      else if (v)      check("R3 R7 byte step", model);
      else if (s)      check("R2 start", model);
      else             check("R4 idle hold", model);
      if (i == 24) check("R6 known answer", 16'hE569);
    end

    // R4: several idle cycles with changing data
    drive(1'b0, 1'b1, 8'h5A);
    model = refStep(16'hFFFF, 8'h5A);
    check("R3 single byte", model);
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b0, 8'(k * 37 + 1));
      check("R4 data ignored when idle", model);
    end

    // R7: long run of consecutive bytes
    for (int k = 0; k < 40; k++) begin
      model = refStep(model, 8'(k * 13));
      drive(1'b0, 1'b1, 8'(k * 13));
    end
    check("R7 consecutive run", model);

    // R1: reset mid-packet
    pktStart = 1'b0;
    byteValid = 1'b1;
    byteIn = 8'hC3;
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-packet reset", 16'hFFFF);
    rstN = 1'b1;
    byteValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 held after reset", 16'hFFFF);

    finishRun();
  end

endmodule